// File: doc/BRIEF.md
# Fine Frequency Correction Strobe Generator

This block paces small corrections to a time-of-day counter. Software programs two registers. The control register holds an enable bit and a direction bit. The interval register holds a 30-bit interval and a unit bit. The interval is the elapsed time between two successive 1 ns corrections. The unit bit states whether that interval is counted in picoseconds or in nanoseconds. Nanosecond counting is meant for very small corrections, where the picosecond figure would not fit in 30 bits.

While enabled, an accumulator adds the reference clock period on every cycle. It adds the period in picoseconds or in nanoseconds, following the unit bit. When the accumulated time reaches or passes the interval, the block does three things in the same cycle:
- it pulses a strobe for one cycle;
- it drives the direction bit beside the strobe, where 1 means slow down (skip a nanosecond) and 0 means speed up (add one);
- it subtracts the interval and keeps the remainder, so the average rate stays exact.

Any write to either register clears the accumulator. Writing zero to the control register turns correction off.

Top module: `fine_adj_gen`

## Requirements
- R1: After reset, both registers read zero, the accumulator is zero and corr_strobe is low.
- R2: Register index 0 is the control register: bit 0 enables correction and bit 1 sets the direction (1 = slow down). Index 1 is the interval register: bits 29:0 hold the interval and bit 30 is the unit bit (1 = nanoseconds). Writes to index 0 or 1 take effect on the next clock edge, and rd_data returns the register that rd_addr selects without delay.
- R3: While enable is 0, corr_strobe stays low and the accumulator holds at zero. Writing zero to the control register therefore stops correction.
- R4: While enabled with unit 0, the accumulator grows by CLK_PS on each cycle. With unit 1 it grows by CLK_NS on each cycle.
- R5: In a cycle where the accumulator plus the step is at or above the interval, corr_strobe is high for exactly that one cycle. The accumulator then becomes that sum minus the interval, so the remainder is kept.
- R6: corr_dir equals the direction bit whenever corr_strobe is high, and is 0 otherwise.
- R7: Any register write clears the accumulator, and no strobe is produced in the cycle of the write.
- R8: An interval of zero while enabled gives a strobe on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Register index for the read |
| rd_data | output | 32 | Read data |
| corr_strobe | output | 1 | One-cycle correction pulse |
| corr_dir | output | 1 | Direction of the correction (1 = slow) |

## Verification
A wrong accumulator value shows up as a strobe that comes one or more cycles early or late, compared with the reference model's remainder arithmetic. The timing drifts further with each strobe that follows. The bench compares corr_strobe and corr_dir on every cycle, so a wrong remainder or step is reported on the first strobe that misfires. A clear that fails to happen on a write shows as a strobe at the wrong point of the next interval.

// File: rtl/fine_adj_gen.sv
module fine_adj_gen #(
  parameter int IW     = 30,
  parameter int CLK_PS = 6400,
  parameter int CLK_NS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  output logic        corr_strobe,
  output logic        corr_dir
);
  localparam int AW = IW + 1;

  logic          ena_q, dir_q, unit_q;
  logic [IW-1:0] ival_q;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] step, sum;
  logic          hit;

  assign step = unit_q ? AW'(CLK_NS) : AW'(CLK_PS);
  assign sum  = acc_q + step;
  assign hit  = ena_q && !wr_en && (sum >= {1'b0, ival_q});

  assign corr_strobe = hit;
  assign corr_dir    = hit & dir_q;

  assign rd_data = rd_addr ? {1'b0, unit_q, ival_q} : {30'd0, dir_q, ena_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q  <= 1'b0;
      dir_q  <= 1'b0;
      unit_q <= 1'b0;
      ival_q <= '0;
      acc_q  <= '0;
    end else if (wr_en) begin
      acc_q <= '0;
      if (wr_addr) begin
        ival_q <= wr_data[IW-1:0];
        unit_q <= wr_data[IW];
      end else begin
        ena_q <= wr_data[0];
        dir_q <= wr_data[1];
      end
    end else if (!ena_q) begin
      acc_q <= '0;
    end else if (hit) begin
      acc_q <= sum - {1'b0, ival_q};
    end else begin
      acc_q <= sum;
    end
  end
endmodule

module fine_adj_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic corr_strobe,
  input logic corr_dir,
  input logic [31:0] rd_data,
  input logic rd_addr
);
  a_r7_no_strobe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !corr_strobe);
  a_r6_dir_only_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    corr_dir |-> corr_strobe);
  a_r3_off_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_addr && !rd_data[0]) |-> !corr_strobe);
  a_r2_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr |-> (rd_data[31:2] == 30'd0));
endmodule

bind fine_adj_gen fine_adj_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .corr_strobe(corr_strobe),
  .corr_dir(corr_dir), .rd_data(rd_data), .rd_addr(rd_addr));

// File: tb/fine_adj_gen_tb_top.sv
module fine_adj_gen_tb_top;
  localparam int TCLK = 10;
  localparam longint PS = 6400;
  localparam longint NS = 6;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic corr_strobe, corr_dir;
  int checks = 0, errors = 0;

  bit m_ena, m_dir, m_unit;
  longint m_ival, m_acc;
  int strobes = 0;

  always #(TCLK/2) clk = ~clk;

  fine_adj_gen dut_i (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: checks outputs mid-cycle, updates at the edge.
  always @(negedge clk) if (rst_n) begin
    bit h;
    longint s;
    s = m_acc + (m_unit ? NS : PS);
    h = m_ena && !wr_en && (s >= m_ival);
    chk("R5 strobe", corr_strobe, h);
    chk("R6 dir", corr_dir, h & m_dir);
    if (h) strobes++;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ena = 0; m_dir = 0; m_unit = 0; m_ival = 0; m_acc = 0;
    end else if (wr_en) begin
      m_acc = 0;
      if (wr_addr) begin m_ival = wr_data[29:0]; m_unit = wr_data[30]; end
      else begin m_ena = wr_data[0]; m_dir = wr_data[1]; end
    end else if (!m_ena) m_acc = 0;
    else begin
      longint s;
      s = m_acc + (m_unit ? NS : PS);
      m_acc = (s >= m_ival) ? s - m_ival : s;
    end
  end

  task automatic wr(input bit a, input logic [31:0] d);
    @(posedge clk); #1; wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic count(input int n, output int got);
    int s0;
    s0 = strobes;
    repeat (n) @(posedge clk);
    #1; got = strobes - s0;
  endtask

  initial begin
    fork begin
      #(TCLK * 150000);
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end join_none
    repeat (3) @(posedge clk);
    #1;
    chk("R1 strobe", corr_strobe, 0);
    rd_addr = 0; #1 chk("R1 ctrl", rd_data, 0);
    rd_addr = 1; #1 chk("R1 ival", rd_data, 0);
    rst_n = 1;
    begin
      int g;
      wr(1, 32'd64000);            // 10 cycles per strobe in ps
      rd_addr = 1; #1 chk("R2 ival readback", rd_data, 64000);
      count(50, g); chk("R3 disabled", g, 0);
      wr(0, 32'h1);
      rd_addr = 0; #1 chk("R2 ctrl readback", rd_data, 1);
      count(100, g); chk("R4 ps rate", g, 10);
      wr(1, 32'd30000);            // non-multiple: remainder kept
      count(300, g);
      chk("R5 remainder rate", g, 64);
      wr(0, 32'h3);                // direction slow
      count(40, g);
      wr(1, 32'h4000_0000 | 32'd60);  // ns unit, 10 cycles
      rd_addr = 1; #1 chk("R2 unit bit", rd_data[30], 1);
      count(100, g); chk("R4 ns rate", g, 10);
      wr(1, 32'd0);
      count(20, g); chk("R8 zero interval", g, 20);
      wr(1, 32'd640000);            // 100 cycles
      repeat (60) begin @(posedge clk); #1; wr_en = 1; wr_addr = 0; wr_data = 32'h1; end
      @(posedge clk); #1 wr_en = 0;
      count(60, g); chk("R7 write clears acc", g, 0);
      wr(0, 32'h0);
      count(300, g); chk("R3 zero write stops", g, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule